// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block connects a simple word request port to one DRAM device whose row and column addresses share a single set of address pins. Each accepted request becomes a row phase and then a column phase: the row half of the word address is placed on the pins while the row strobe falls, and the column half follows on the same pins with a column strobe. The device loses the contents of a row as soon as that row is read into its row buffer. The controller therefore keeps the row strobe low through a restore stage and lets the buffer be written back before the row closes and the precharge wait begins.

A row that was opened for an access stays open after the access when `PAGE_MODE` is set. A following request to that row needs only a new column phase. A request to another row first closes and restores the open row. A free-running interval timer requests a row-only refresh of one row at a time, and a row counter steps through all rows and wraps. A refresh that falls due takes precedence over any waiting request, and an open page is closed before the refresh starts. Every delay is a parameter in clock cycles.

Top module: `dram_mux_ctrl`

## Requirements
- R1: After reset the row strobe, column strobe and write strobe are all high (inactive), `rd_valid` is low, and `req_ready` is high.
- R2: The word address splits as row = `req_addr[ROW_BITS+COL_BITS-1:COL_BITS]` and column = `req_addr[COL_BITS-1:0]`. Each half is zero-extended onto `dram_addr`. The row value is on the pins in every cycle the row strobe is newly low, and the column value is on the pins while the column strobe is low.
- R3: The column strobe is low only while the row strobe is low. It first falls no sooner than `T_RCD` cycles after the row strobe fell. Between two row openings the row strobe stays high for at least `T_RP` cycles.
- R4: A read returns the word stored at its address on `rd_data`, together with a `rd_valid` pulse exactly one cycle wide.
- R5: A write stores `req_wdata` at the addressed word. The write strobe is low only during the column phase, and the data output is enabled during that phase.
- R6: Every row that is opened is written back to the array before it closes. Data survives the destructive row read across any sequence of rows.
- R7: With page mode on, a request to the row that is already open causes no new row opening, only another column phase.
- R8: A request to a row other than the open one closes and restores the open row, waits out the precharge, and then opens the new row.
- R9: A refresh is one row-only opening that is held for `T_REF` cycles and issued about once every `REF_INTERVAL` cycles. Successive refreshes address rows in increasing order and wrap from the last row to row 0. No row goes longer than the retention window without a restore.
- R10: When a refresh is due it takes precedence over waiting and new requests (`req_ready` low), and an open page is closed before the refresh row opens.
- R11: A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low in the cycle after a request is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_BITS+COL_BITS | Word address, row in the upper bits |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle pulse marking read data |
| rd_data | output | DATA_W | Read data |
| dram_addr | output | PIN_BITS | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_dq_out | output | DATA_W | Data driven to the device |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | DATA_W | Data returned by the device |

## Verification
A refresh falling due and a request waiting to be served can occur in the same cycle, and a refresh can also fall due while a page is held open. The bench provokes the first case with an unbroken stream of writes and reads that runs over many refresh intervals, and the second by leaving a page open past a refresh point. A bench-side device model poisons each row when it is opened and restores it only when the row strobe rises. Results are judged on the number of refreshes, on the order of refreshed rows, on the absence of any retention or strobe-timing violation, on correct read data, and on the extra row opening needed after the refresh has closed the page.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // no row open, precharged
        ST_ACT,    // row strobe low, row address out
        ST_CAS,    // column strobe low
        ST_OPEN,   // page held open, waiting
        ST_RST,    // row restore before close
        ST_PRE,    // precharge, row strobe high
        ST_REF     // row-only refresh
    } seq_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
    parameter int ROW_BITS     = 11,
    parameter int REF_INTERVAL = 195
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ref_ack,
    output logic                ref_due,
    output logic [ROW_BITS-1:0] ref_row
);
    localparam int CW = $clog2(REF_INTERVAL + 1);
    localparam logic [ROW_BITS-1:0] LAST_ROW = {ROW_BITS{1'b1}};
    localparam logic [CW-1:0] CNT_END = CW'(REF_INTERVAL - 1);

    logic [CW-1:0] tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick    <= '0;
            ref_due <= 1'b0;
            ref_row <= '0;
        end else begin
            if (tick == CNT_END) begin
                tick    <= '0;
                ref_due <= 1'b1;
            end else begin
                tick <= tick + 1'b1;
                if (ref_ack) ref_due <= 1'b0;
            end
            if (ref_ack)
                ref_row <= (ref_row == LAST_ROW) ? '0 : ref_row + 1'b1;
        end
    end

    // R9
    ref_due_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_due && !ref_ack) |=> ref_due);

    // R9
    ref_row_step_chk: assert property (@(posedge clk) disable iff (rst)
        ref_ack |=> (ref_row == (($past(ref_row) == LAST_ROW) ? '0 : $past(ref_row) + 1'b1)));

endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dram_ctl_pkg::*;
#(
    parameter int ROW_BITS  = 11,
    parameter int COL_BITS  = 11,
    parameter int PIN_BITS  = 12,
    parameter int DATA_W    = 8,
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 2,
    parameter int T_RST     = 2,
    parameter int T_RP      = 3,
    parameter int T_REF     = 4,
    parameter int PAGE_MODE = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_we,
    input  logic [ROW_BITS+COL_BITS-1:0] req_addr,
    input  logic [DATA_W-1:0]            req_wdata,
    output logic                         rd_valid,
    output logic [DATA_W-1:0]            rd_data,
    input  logic                         ref_due,
    input  logic [ROW_BITS-1:0]          ref_row,
    output logic                         ref_ack,
    output logic [PIN_BITS-1:0]          dram_addr,
    output logic                         dram_ras_n,
    output logic                         dram_cas_n,
    output logic                         dram_we_n,
    output logic [DATA_W-1:0]            dram_dq_out,
    output logic                         dram_dq_oe,
    input  logic [DATA_W-1:0]            dram_dq_in
);
    localparam int WORD_AW = ROW_BITS + COL_BITS;
    localparam int T_MAX   = max_of(max_of(max_of(T_RCD, T_CAS), max_of(T_RST, T_RP)), T_REF);
    localparam int TW      = $clog2(T_MAX + 1) + 1;
    localparam logic KEEP_OPEN = (PAGE_MODE != 0);

    typedef struct packed {
        logic                we;
        logic [ROW_BITS-1:0] row;
        logic [COL_BITS-1:0] col;
        logic [DATA_W-1:0]   wdata;
    } acc_t;

    seq_state_e state;
    logic [TW-1:0] tmr;
    acc_t cur, incoming;
    logic pend;
    logic accept, tmr_done;

    assign incoming = '{we: req_we, row: req_addr[WORD_AW-1:COL_BITS],
                        col: req_addr[COL_BITS-1:0], wdata: req_wdata};
    assign req_ready = !pend && !ref_due && (state == ST_IDLE || state == ST_OPEN);
    assign accept    = req_valid && req_ready;
    assign tmr_done  = (tmr == '0);
    assign ref_ack   = (state == ST_REF) && tmr_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            tmr      <= '0;
            cur      <= '0;
            pend     <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (ref_due) begin
                        state <= ST_REF;
                        tmr   <= TW'(T_REF - 1);
                    end else if (pend) begin
                        pend  <= 1'b0;
                        state <= ST_ACT;
                        tmr   <= TW'(T_RCD - 1);
                    end else if (accept) begin
                        cur   <= incoming;
                        state <= ST_ACT;
                        tmr   <= TW'(T_RCD - 1);
                    end
                end
                ST_ACT: begin
                    if (tmr_done) begin
                        state <= ST_CAS;
                        tmr   <= TW'(T_CAS - 1);
                    end else tmr <= tmr - 1'b1;
                end
                ST_CAS: begin
                    if (tmr_done) begin
                        if (!cur.we) begin
                            rd_data  <= dram_dq_in;
                            rd_valid <= 1'b1;
                        end
                        if (KEEP_OPEN) state <= ST_OPEN;
                        else begin
                            state <= ST_RST;
                            tmr   <= TW'(T_RST - 1);
                        end
                    end else tmr <= tmr - 1'b1;
                end
                ST_OPEN: begin
                    if (ref_due) begin
                        state <= ST_RST;
                        tmr   <= TW'(T_RST - 1);
                    end else if (accept) begin
                        cur <= incoming;
                        if (incoming.row == cur.row) begin
                            state <= ST_CAS;
                            tmr   <= TW'(T_CAS - 1);
                        end else begin
                            pend  <= 1'b1;
                            state <= ST_RST;
                            tmr   <= TW'(T_RST - 1);
                        end
                    end
                end
                ST_RST: begin
                    if (tmr_done) begin
                        state <= ST_PRE;
                        tmr   <= TW'(T_RP - 1);
                    end else tmr <= tmr - 1'b1;
                end
                ST_PRE: begin
                    if (tmr_done) state <= ST_IDLE;
                    else tmr <= tmr - 1'b1;
                end
                ST_REF: begin
                    if (tmr_done) begin
                        state <= ST_PRE;
                        tmr   <= TW'(T_RP - 1);
                    end else tmr <= tmr - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        dram_ras_n  = !(state inside {ST_ACT, ST_CAS, ST_OPEN, ST_RST, ST_REF});
        dram_cas_n  = (state != ST_CAS);
        dram_dq_oe  = (state == ST_CAS) && cur.we;
        dram_we_n   = !dram_dq_oe;
        dram_dq_out = cur.wdata;
        unique case (state)
            ST_REF:  dram_addr = PIN_BITS'(ref_row);
            ST_ACT:  dram_addr = PIN_BITS'(cur.row);
            default: dram_addr = PIN_BITS'(cur.col);
        endcase
    end

    // R3
    cas_inside_ras_chk: assert property (@(posedge clk) disable iff (rst)
        !dram_cas_n |-> !dram_ras_n);

    // R3
    row_open_no_cas_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_ras_n) |-> dram_cas_n);

    // R3
    precharge_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dram_ras_n) |=> dram_ras_n);

    // R4
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R11
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R5
    we_in_cas_chk: assert property (@(posedge clk) disable iff (rst)
        !dram_we_n |-> !dram_cas_n);

endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
    parameter int ROW_BITS     = 11,
    parameter int COL_BITS     = 11,
    parameter int PIN_BITS     = 12,
    parameter int DATA_W       = 8,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_RST        = 2,
    parameter int T_RP         = 3,
    parameter int T_REF        = 4,
    parameter int REF_INTERVAL = 195,
    parameter int PAGE_MODE    = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_we,
    input  logic [ROW_BITS+COL_BITS-1:0] req_addr,
    input  logic [DATA_W-1:0]            req_wdata,
    output logic                         rd_valid,
    output logic [DATA_W-1:0]            rd_data,
    output logic [PIN_BITS-1:0]          dram_addr,
    output logic                         dram_ras_n,
    output logic                         dram_cas_n,
    output logic                         dram_we_n,
    output logic [DATA_W-1:0]            dram_dq_out,
    output logic                         dram_dq_oe,
    input  logic [DATA_W-1:0]            dram_dq_in
);
    logic                ref_due, ref_ack;
    logic [ROW_BITS-1:0] ref_row;

    dram_ref_timer #(
        .ROW_BITS(ROW_BITS), .REF_INTERVAL(REF_INTERVAL)
    ) u_timer (
        .clk(clk), .rst(rst), .ref_ack(ref_ack),
        .ref_due(ref_due), .ref_row(ref_row)
    );

    dram_seq #(
        .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .PIN_BITS(PIN_BITS),
        .DATA_W(DATA_W), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RST(T_RST),
        .T_RP(T_RP), .T_REF(T_REF), .PAGE_MODE(PAGE_MODE)
    ) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .ref_due(ref_due), .ref_row(ref_row), .ref_ack(ref_ack),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

endmodule

// File: tb/dram_mux_ctrl_test.sv
`timescale 1ns/1ps
module dram_mux_ctrl_test;
    localparam int RB = 4, CB = 4, PB = 6, DW = 8;
    localparam int NR = 1 << RB, NC = 1 << CB;
    localparam int TRCD = 2, TCAS = 2, TRST = 2, TRP = 2, TREF = 3, RINT = 60;
    localparam int RETAIN = NR * RINT + 40;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [RB+CB-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rd_valid;
    logic [DW-1:0] rd_data, dq_out, dq_in;
    logic [PB-1:0] dram_addr;
    logic ras_n, cas_n, we_n, dq_oe;

    always #2.5 clk = ~clk;

    dram_mux_ctrl #(
        .ROW_BITS(RB), .COL_BITS(CB), .PIN_BITS(PB), .DATA_W(DW),
        .T_RCD(TRCD), .T_CAS(TCAS), .T_RST(TRST), .T_RP(TRP), .T_REF(TREF),
        .REF_INTERVAL(RINT), .PAGE_MODE(1)
    ) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
        .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
    );

    // ---------------- behavioural device model (sampled at negedge) ----------
    logic [DW-1:0] arr [NR][NC];
    logic [DW-1:0] rbuf [NC];
    int last_fix [NR];
    int cyc = 0, open_row = 0, low_cnt = 0, high_cnt = 1000;
    int fall_cnt = 0, ref_cnt = 0, last_ref = 0, wraps = 0;
    int tim_err = 0, seq_err = 0, ret_err = 0;
    int act_row = -1, cas_col = -1;
    logic prev_ras = 1'b1, prev_cas = 1'b1, saw_cas = 1'b0;

    assign dq_in = (!cas_n && we_n) ? rbuf[dram_addr[CB-1:0]] : '0;

    always @(negedge clk) begin
        if (rst) begin
            for (int r = 0; r < NR; r++) begin
                last_fix[r] = 0;
                for (int c = 0; c < NC; c++) arr[r][c] = DW'(r * NC + c);
            end
            for (int c = 0; c < NC; c++) rbuf[c] = '0;
            cyc = 0; prev_ras = 1'b1; prev_cas = 1'b1; high_cnt = 1000;
        end else begin
            cyc++;
            if (!ras_n && prev_ras) begin
                if (high_cnt < TRP) tim_err++;
                fall_cnt++;
                open_row = int'(dram_addr[RB-1:0]);
                act_row  = open_row;
                if (dram_addr >= PB'(NR)) tim_err++;
                for (int c = 0; c < NC; c++) begin
                    rbuf[c] = arr[open_row][c];
                    arr[open_row][c] = 8'hEE;      // destructive read
                end
                low_cnt = 1; saw_cas = 1'b0;
            end else if (!ras_n) low_cnt++;
            if (ras_n && !prev_ras) begin
                for (int c = 0; c < NC; c++) arr[open_row][c] = rbuf[c];
                last_fix[open_row] = cyc;
                if (low_cnt < TREF) tim_err++;
                if (!saw_cas) begin
                    if (ref_cnt > 0 && open_row != (last_ref + 1) % NR) seq_err++;
                    if (ref_cnt > 0 && open_row == 0) wraps++;
                    last_ref = open_row;
                    ref_cnt++;
                end
                high_cnt = 1;
            end else if (ras_n) high_cnt++;
            if (!cas_n) begin
                if (ras_n) tim_err++;
                if (prev_cas) begin
                    if (low_cnt <= TRCD) tim_err++;
                    saw_cas = 1'b1;
                    cas_col = int'(dram_addr);
                end
                if (!we_n) begin
                    if (!dq_oe) tim_err++;
                    rbuf[dram_addr[CB-1:0]] = dq_out;
                end
            end else if (!we_n) tim_err++;
            for (int r = 0; r < NR; r++)
                if ((ras_n || r != open_row) && (cyc - last_fix[r] > RETAIN)) ret_err++;
            prev_ras = ras_n; prev_cas = cas_n;
        end
    end

    // ---------------- bench bookkeeping ----------------
    int checks = 0, errors = 0;
    logic [DW-1:0] shadow [NR*NC];
    logic done = 1'b0;

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic check_true(input string req, input bit ok, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic issue(input logic we, input int addr, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = (RB+CB)'(addr); req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (we) shadow[addr] = d;
    endtask

    task automatic rd_check(input string req, input int addr);
        int w = 0;
        issue(1'b0, addr, '0);
        while (!rd_valid && w < 100) begin @(negedge clk); w++; end
        check(req, int'(rd_data), int'(shadow[addr]));
        @(negedge clk);
        check({req, " valid width"}, int'(rd_valid), 0);
    endtask

    task automatic sync_after_ref();
        int start = ref_cnt;
        while (ref_cnt == start) @(negedge clk);
        repeat (TRP + 1) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 ras_n", int'(ras_n), 1);
        check("R1 cas_n", int'(cas_n), 1);
        check("R1 we_n", int'(we_n), 1);
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 req_ready", int'(req_ready), 1);
    endtask

    task automatic t_write_read();
        issue(1'b1, 8'h37, 8'h5A);
        check("R11 ready low after take", int'(req_ready), 0);
        rd_check("R5 R4 write then read", 8'h37);
        check("R2 row on pins", act_row, 3);
        check("R2 column on pins", cas_col, 7);
    endtask

    task automatic t_page_hit();
        int f0;
        sync_after_ref();
        f0 = fall_cnt;
        rd_check("R4 page hit first", 8'h51);
        rd_check("R4 page hit second", 8'h5C);
        check("R7 one opening for same row", fall_cnt - f0, 1);
    endtask

    task automatic t_page_miss();
        int f0;
        sync_after_ref();
        f0 = fall_cnt;
        issue(1'b1, 8'hA4, 8'hC3);
        rd_check("R8 other row", 8'h92);
        rd_check("R6 first row restored", 8'hA4);
        check("R8 three openings", fall_cnt - f0, 3);
    endtask

    task automatic t_ref_closes_page();
        int f0, r0;
        sync_after_ref();
        f0 = fall_cnt; r0 = ref_cnt;
        rd_check("R10 before refresh", 8'h6B);
        while (ref_cnt == r0) @(negedge clk);
        rd_check("R10 after refresh", 8'h6B);
        check("R10 page reopened after refresh", (fall_cnt - f0) - (ref_cnt - r0), 2);
    endtask

    task automatic t_refresh_idle();
        int r0 = ref_cnt;
        repeat (RINT * 20) @(negedge clk);
        check_true("R9 refresh count over 20 intervals",
                   (ref_cnt - r0) >= 19 && (ref_cnt - r0) <= 21, ref_cnt - r0, 20);
        check_true("R9 row counter wrapped", wraps >= 1, wraps, 1);
    endtask

    task automatic t_stream();
        int r0 = ref_cnt, c0 = cyc;
        for (int k = 0; k < 120; k++) begin
            int a = (k * 37 + 11) % (NR * NC);
            issue(1'b1, a, DW'(k * 13 + 1));
            if (k % 3 == 2) rd_check("R10 R6 stream read", (k * 29 + 5) % (NR * NC));
        end
        check_true("R10 refresh kept pace under load",
                   (ref_cnt - r0) >= (cyc - c0) / RINT - 1, ref_cnt - r0, (cyc - c0) / RINT);
        for (int a = 0; a < NR * NC; a += 17) rd_check("R6 final readback", a);
    endtask

    initial begin
        for (int a = 0; a < NR * NC; a++) shadow[a] = DW'(a);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_page_hit();
        t_page_miss();
        t_ref_closes_page();
        t_refresh_idle();
        t_stream();
        check("R3 strobe timing violations", tim_err, 0);
        check("R9 refresh order violations", seq_err, 0);
        check("R9 retention violations", ret_err, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got 150000 cycles expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule